// File: doc/BRIEF.md
# Type-C Dual-Role Attach Controller

This block decides the power role of a dual-role USB Type-C port. While no partner is attached, it alternates the port between offering a source pull-up (Rp) and a sink pull-down (Rd). The toggle period and the share of that period spent as a source are programmable. An uneven split makes the port more likely to end up as a source or as a sink when two dual-role ports meet. The CC lines are sensed by analog comparators outside the block. The block receives their results as three flags: partner pull-down seen, partner pull-up seen, and audio accessory seen. It also receives a millisecond tick.

A partner pull-down that stays present during the pull-up phase for a debounce count of ticks makes the port a source. The block then enables the 5 V boost, starts advertising default current, and allows software to raise that advertisement step by step. When the partner leaves, the block turns the boost off and holds a VBUS discharge path on until VBUS is reported low. A timeout ends the discharge and flags an error. A partner pull-up that stays present during the pull-down phase makes the port a sink. The sink returns to toggling directly on detach or when VBUS is lost. An audio accessory is reported with its own attach code.

Top module: `drp_role_ctrl`

## Requirements
- R1: After reset the block is toggling at phase position 0 with `pull_up`=1, `attach_code`=00, `boost_en`=0, `discharge_en`=0, `adv_cur`=00 and `dis_err`=0.
- R2: While toggling, the phase position counts 0..P-1 and wraps. P is `period_ms` clamped to 50..100, and D is `src_duty` clamped to 30..70. `pull_up` is 1 exactly when position*100 < P*D, so each period has ceil(P*D/100) pull-up ticks followed by pull-down ticks.
- R3: The phase position advances only on a cycle with `tick`=1. It does not advance while a candidate partner is present.
- R4: `rd_seen` held during the pull-up phase for 4 ticks makes the port a source. The outputs are then `attach_code`=01, `boost_en`=1, `pull_up`=1 and `adv_cur`=01. After 3 such ticks the port is still unattached.
- R5: `rp_seen` has no effect during the pull-up phase. When held during the pull-down phase for 4 ticks, it makes the port a sink with `attach_code`=10, `boost_en`=0 and `pull_up`=0.
- R6: `audio_seen` held for 4 ticks gives `attach_code`=11 with the boost off. It takes priority over `rd_seen` and `rp_seen`. `detach` returns the port to toggling.
- R7: A candidate that goes away before its 4th tick produces no attachment. Toggling resumes from the position at which it froze.
- R8: `detach` while a source turns the boost off and sets `discharge_en`=1, `attach_code`=00 and `adv_cur`=00. Discharge continues until `vbus_low`=1. The port then toggles again from position 0.
- R9: If `vbus_low` is not seen within 20 ticks of discharge, the block sets `dis_err`=1, stops discharging and toggles from position 0. `dis_err` clears when the next attachment is accepted.
- R10: A sink returns directly to toggling at position 0 on `detach` or `vbus_low`, and `discharge_en` stays 0.
- R11: While a source, each `adv_raise` pulse raises `adv_cur` one step (01 default, 10 1.5 A, 11 3.0 A), saturating at 11. It never lowers `adv_cur`. Outside the source states, `adv_cur`=00 and `adv_raise` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time base pulse (1 ms) |
| period_ms | input | 7 | Toggle period in ticks, clamped to 50..100 |
| src_duty | input | 7 | Pull-up share of the period in percent, clamped to 30..70 |
| rd_seen | input | 1 | Partner pull-down detected |
| rp_seen | input | 1 | Partner pull-up detected |
| audio_seen | input | 1 | Audio accessory detected |
| detach | input | 1 | Partner detached or error |
| vbus_low | input | 1 | VBUS below 0.8 V |
| adv_raise | input | 1 | Request one step more advertised current |
| pull_up | output | 1 | 1 = present Rp, 0 = present Rd |
| attach_code | output | 2 | 00 none, 01 source, 10 sink, 11 audio accessory |
| boost_en | output | 1 | 5 V boost enable |
| discharge_en | output | 1 | VBUS discharge path enable |
| adv_cur | output | 2 | Source current advertisement |
| dis_err | output | 1 | Discharge timed out |

## Verification
The embedded properties are checked on every cycle. They cover these points: the toggle position stays frozen while a candidate is pending, and discharge only ever follows a boost-on state. A source attachment always starts at default advertisement, and the advertisement never drops while the boost stays on. The discharge counter stays below its limit, and a sink never leaves into discharge. Some behaviour can only be shown by the bench scenarios. This includes the exact number of pull-up ticks for each clamped period and duty, the debounce count of 4, resuming from the frozen position, the 20-tick discharge timeout and the clearing of its error, audio priority, and saturation of the current advertisement.

// File: rtl/drp_role_ctrl.sv
module drp_role_ctrl #(
  parameter int PER_MIN   = 50,
  parameter int PER_MAX   = 100,
  parameter int DUTY_MIN  = 30,
  parameter int DUTY_MAX  = 70,
  parameter int DEB_TICKS = 4,
  parameter int DIS_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [6:0] period_ms,
  input  logic [6:0] src_duty,
  input  logic       rd_seen,
  input  logic       rp_seen,
  input  logic       audio_seen,
  input  logic       detach,
  input  logic       vbus_low,
  input  logic       adv_raise,
  output logic       pull_up,
  output logic [1:0] attach_code,
  output logic       boost_en,
  output logic       discharge_en,
  output logic [1:0] adv_cur,
  output logic       dis_err
);
  localparam int PW  = 7;
  localparam int MW  = $clog2(PER_MAX * 100 + 1);
  localparam int DBW = $clog2(DEB_TICKS + 1);
  localparam int TW  = $clog2(DIS_TICKS + 1);

  typedef enum logic [2:0] {S_TOG, S_ATT_SRC, S_SRC_ACT, S_DISCH, S_ATT_SNK, S_SNK_ACT, S_AUDIO} st_t;
  typedef enum logic [1:0] {C_NONE = 2'b00, C_SRC = 2'b01, C_SNK = 2'b10, C_AUD = 2'b11} cand_t;

  st_t            st;
  cand_t          cand, deb_kind;
  logic [PW-1:0]  phase;
  logic [DBW-1:0] deb_cnt;
  logic [TW-1:0]  dis_cnt;
  logic [1:0]     adv_q;
  logic           err_q;

  logic [PW-1:0] per_eff, duty_eff;
  assign per_eff  = (period_ms < PW'(PER_MIN)) ? PW'(PER_MIN) :
                    (period_ms > PW'(PER_MAX)) ? PW'(PER_MAX) : period_ms;
  assign duty_eff = (src_duty < PW'(DUTY_MIN)) ? PW'(DUTY_MIN) :
                    (src_duty > PW'(DUTY_MAX)) ? PW'(DUTY_MAX) : src_duty;

  logic rp_phase;
  assign rp_phase = (MW'(phase) * MW'(100)) < (MW'(per_eff) * MW'(duty_eff));

  always_comb begin
    cand = C_NONE;
    if (st == S_TOG) begin
      if (audio_seen)             cand = C_AUD;
      else if (rp_phase && rd_seen)  cand = C_SRC;
      else if (!rp_phase && rp_seen) cand = C_SNK;
    end
  end

  logic src_state;
  assign src_state    = (st == S_ATT_SRC) || (st == S_SRC_ACT);
  assign boost_en     = src_state;
  assign discharge_en = (st == S_DISCH);
  assign adv_cur      = src_state ? adv_q : 2'b00;
  assign dis_err      = err_q;
  assign pull_up      = (st == S_TOG) ? rp_phase : (src_state || st == S_DISCH);
  assign attach_code  = src_state ? 2'b01 :
                        ((st == S_ATT_SNK) || (st == S_SNK_ACT)) ? 2'b10 :
                        (st == S_AUDIO) ? 2'b11 : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_TOG;
      phase    <= '0;
      deb_kind <= C_NONE;
      deb_cnt  <= '0;
      dis_cnt  <= '0;
      adv_q    <= 2'b00;
      err_q    <= 1'b0;
    end else begin
      if (src_state && adv_raise && adv_q != 2'b11) adv_q <= adv_q + 2'b01;
      case (st)
        S_TOG: begin
          if (cand != deb_kind) begin
            deb_kind <= cand;
            deb_cnt  <= '0;
          end else if (tick) begin
            if (cand == C_NONE) begin
              phase <= (phase >= per_eff - PW'(1)) ? '0 : phase + PW'(1);
            end else if (deb_cnt == DBW'(DEB_TICKS - 1)) begin
              deb_kind <= C_NONE;
              deb_cnt  <= '0;
              err_q    <= 1'b0;
              adv_q    <= 2'b01;
              st       <= (cand == C_SRC) ? S_ATT_SRC : (cand == C_SNK) ? S_ATT_SNK : S_AUDIO;
            end else begin
              deb_cnt <= deb_cnt + DBW'(1);
            end
          end
        end
        S_ATT_SRC, S_SRC_ACT: begin
          if (detach) begin
            st      <= S_DISCH;
            dis_cnt <= '0;
          end else begin
            st <= S_SRC_ACT;
          end
        end
        S_DISCH: begin
          if (vbus_low) begin
            st    <= S_TOG;
            phase <= '0;
          end else if (tick) begin
            if (dis_cnt == TW'(DIS_TICKS - 1)) begin
              err_q <= 1'b1;
              st    <= S_TOG;
              phase <= '0;
            end else begin
              dis_cnt <= dis_cnt + TW'(1);
            end
          end
        end
        S_ATT_SNK: begin
          if (detach) begin
            st    <= S_TOG;
            phase <= '0;
          end else if (!vbus_low) begin
            st <= S_SNK_ACT;
          end
        end
        S_SNK_ACT: begin
          if (detach || vbus_low) begin
            st    <= S_TOG;
            phase <= '0;
          end
        end
        S_AUDIO: begin
          if (detach) begin
            st    <= S_TOG;
            phase <= '0;
          end
        end
        default: st <= S_TOG;
      endcase
    end
  end

  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TOG && cand != C_NONE) |=> phase == $past(phase)); // R3
  AST_DISCH_AFTER_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discharge_en) |-> $past(boost_en)); // R8
  AST_ADV_START_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_en) |-> adv_cur == 2'b01); // R4
  AST_ADV_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (boost_en && $past(boost_en)) |-> adv_cur >= $past(adv_cur)); // R11
  AST_DIS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DISCH) |-> dis_cnt < TW'(DIS_TICKS)); // R9
  AST_SNK_NO_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(attach_code == 2'b10) && attach_code != 2'b10) |-> !discharge_en); // R10
endmodule

// File: tb/tb_drp_role_ctrl.sv
module tb_drp_role_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [6:0] period_ms = 7'd50;
  logic [6:0] src_duty = 7'd30;
  logic rd_seen = 1'b0, rp_seen = 1'b0, audio_seen = 1'b0;
  logic detach = 1'b0, vbus_low = 1'b0, adv_raise = 1'b0;
  logic pull_up, boost_en, discharge_en, dis_err;
  logic [1:0] attach_code, adv_cur;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  localparam int DEB = 4;
  localparam int DIS = 20;

  always #10 clk = ~clk;

  drp_role_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_ms(period_ms), .src_duty(src_duty),
    .rd_seen(rd_seen), .rp_seen(rp_seen), .audio_seen(audio_seen), .detach(detach),
    .vbus_low(vbus_low), .adv_raise(adv_raise), .pull_up(pull_up), .attach_code(attach_code),
    .boost_en(boost_en), .discharge_en(discharge_en), .adv_cur(adv_cur), .dis_err(dis_err)
  );

  function automatic int clamp(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic bit exp_pull(int c, int p, int d);
    return (c * 100) < (clamp(p, 50, 100) * clamp(d, 30, 70));
  endfunction

  function automatic int rp_ticks(int p, int d);
    return (clamp(p, 50, 100) * clamp(d, 30, 70) + 99) / 100;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick_once();
  endtask

  task automatic pulse_detach();
    @(negedge clk) detach = 1'b1;
    @(negedge clk) detach = 1'b0;
  endtask

  task automatic pulse_vbus_low();
    @(negedge clk) vbus_low = 1'b1;
    @(negedge clk) vbus_low = 1'b0;
  endtask

  task automatic pulse_raise();
    @(negedge clk) adv_raise = 1'b1;
    @(negedge clk) adv_raise = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rd_seen = 0; rp_seen = 0; audio_seen = 0; detach = 0; vbus_low = 0; adv_raise = 0; tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic count_to_fall(string tag, int exp);
    int n = 0;
    while (pull_up && n < 120) begin
      tick_once();
      n++;
    end
    chk(tag, n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    chk("R1 pull_up", pull_up, 1);
    chk("R1 attach_code", attach_code, 0);
    chk("R1 boost_en", boost_en, 0);
    chk("R1 discharge_en", discharge_en, 0);
    chk("R1 adv_cur", adv_cur, 0);
    chk("R1 dis_err", dis_err, 0);

    for (int k = 0; k < 6; k++) begin
      int p, d, pc, c, highs;
      p = $urandom_range(40, 110);
      d = $urandom_range(20, 80);
      period_ms = 7'(p);
      src_duty = 7'(d);
      do_reset();
      pc = clamp(p, 50, 100);
      c = 0;
      highs = 0;
      for (int i = 0; i < 2 * pc; i++) begin
        chk("R2 pull_up pattern", pull_up, exp_pull(c, p, d));
        if (i < pc && pull_up) highs++;
        tick_once();
        c = (c + 1) % pc;
      end
      chk("R2 pull-up ticks per period", highs, rp_ticks(p, d));
    end

    period_ms = 7'd50;
    src_duty = 7'd30;
    do_reset();
    ticks(14);
    repeat (20) @(negedge clk);
    chk("R3 no advance without tick", pull_up, 1);
    tick_once();
    chk("R3 advance on tick", pull_up, 0);

    do_reset();
    @(negedge clk) rd_seen = 1'b1;
    ticks(DEB - 1);
    chk("R4 not yet attached", attach_code, 0);
    tick_once();
    chk("R4 attach_code", attach_code, 1);
    chk("R4 boost_en", boost_en, 1);
    chk("R4 adv_cur default", adv_cur, 1);
    repeat (3) @(negedge clk);
    chk("R4 source active", attach_code, 1);
    pulse_raise();
    chk("R11 raise to 1.5A", adv_cur, 2);
    pulse_raise();
    chk("R11 raise to 3.0A", adv_cur, 3);
    pulse_raise();
    chk("R11 saturate", adv_cur, 3);
    rd_seen = 1'b0;
    pulse_detach();
    chk("R8 discharge_en", discharge_en, 1);
    chk("R8 boost_en off", boost_en, 0);
    chk("R8 attach_code", attach_code, 0);
    chk("R8 adv_cur off", adv_cur, 0);
    ticks(5);
    chk("R8 still discharging", discharge_en, 1);
    pulse_vbus_low();
    chk("R8 discharge ends", discharge_en, 0);
    chk("R8 no error", dis_err, 0);
    count_to_fall("R8 restart at position 0", 15);

    do_reset();
    @(negedge clk) rd_seen = 1'b1;
    ticks(DEB);
    rd_seen = 1'b0;
    pulse_detach();
    ticks(DIS - 1);
    chk("R9 before timeout", discharge_en, 1);
    chk("R9 no error yet", dis_err, 0);
    tick_once();
    chk("R9 timeout ends discharge", discharge_en, 0);
    chk("R9 error flag", dis_err, 1);
    @(negedge clk) rp_seen = 1'b1;
    count_to_fall("R5 rp_seen ignored in pull-up phase", 15);
    chk("R5 no attach in pull-up phase", attach_code, 0);
    ticks(DEB - 1);
    chk("R5 not yet attached", attach_code, 0);
    chk("R7 frozen in pull-down phase", pull_up, 0);
    tick_once();
    chk("R5 attach_code sink", attach_code, 2);
    chk("R5 boost off", boost_en, 0);
    chk("R5 pull_up low", pull_up, 0);
    chk("R9 error cleared", dis_err, 1'b0);
    chk("R11 adv off as sink", adv_cur, 0);
    pulse_raise();
    chk("R11 raise ignored as sink", adv_cur, 0);
    rp_seen = 1'b0;
    pulse_vbus_low();
    chk("R10 vbus loss detaches", attach_code, 0);
    chk("R10 no discharge", discharge_en, 0);
    chk("R10 back at position 0", pull_up, 1);
    @(negedge clk) rp_seen = 1'b1;
    count_to_fall("R10 toggles from position 0", 15);
    ticks(DEB);
    chk("R5 second sink attach", attach_code, 2);
    rp_seen = 1'b0;
    pulse_detach();
    chk("R10 detach from sink", attach_code, 0);
    chk("R10 no discharge on detach", discharge_en, 0);

    do_reset();
    @(negedge clk) begin audio_seen = 1'b1; rd_seen = 1'b1; end
    ticks(DEB);
    chk("R6 audio priority", attach_code, 3);
    chk("R6 audio boost off", boost_en, 0);
    audio_seen = 1'b0;
    rd_seen = 1'b0;
    pulse_detach();
    chk("R6 audio detach", attach_code, 0);
    chk("R6 audio no discharge", discharge_en, 0);

    do_reset();
    @(negedge clk) rd_seen = 1'b1;
    ticks(DEB - 1);
    @(negedge clk) rd_seen = 1'b0;
    chk("R7 no attach after early drop", attach_code, 0);
    count_to_fall("R7 resume from frozen position", 15);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule